// File: doc/BRIEF.md
# Transmit FIFO with Data-Request Flag

This block is a small transmit queue that sits in front of a serial shift engine. Software pushes words into it one write at a time. Whenever the FIFO is enabled and the engine reports that its holding register is empty, the oldest word is handed over. Each handover is a single-cycle load strobe with the head word beside it, and the entry is removed in that cycle.

A request flag tells software that the queue has drained and more data is wanted. The flag rises whenever the FIFO holds no entries. Once raised, it is not dropped by the next write. It goes low only when software writes 0 to it, or when the FIFO fills to its full depth. The flag is ANDed with an interrupt enable to form the interrupt line. A count output gives the number of valid entries, and a count of 0 means the FIFO is empty.

Disabling the FIFO only stops handovers. The stored words and the count stay as they are, so re-enabling the FIFO resumes transmission from the same head word.

Top module: `tx_fifo_dreq`

## Requirements
- R1: After reset the count is 0 and the request flag is 1.
- R2: Words leave the FIFO in the order in which they were accepted, and `head_data` carries the oldest word whenever `load_o` is 1.
- R3: A write while the count equals DEPTH is ignored: the count stays at DEPTH and the stored words are unchanged.
- R4: `load_o` is 1 exactly when `fifo_en` is 1, `hold_empty` is 1 and the count is nonzero. The count drops by one on the following clock edge, unless a write is accepted in the same cycle.
- R5: While `fifo_en` is 0, `load_o` stays 0 and the stored words are kept. After re-enabling, the next load delivers the same head word.
- R6: The request flag is 1 in every cycle in which the count reads 0.
- R7: Writing 0 to the flag (`flag_wr`=1, `flag_wdata`=0) clears it on the next edge, provided the count after that edge is neither 0 nor DEPTH.
- R8: Writing 1 to the flag (`flag_wr`=1, `flag_wdata`=1) has no effect on it.
- R9: The flag is 0 in every cycle in which the count reads DEPTH.
- R10: An accepted write that leaves the FIFO neither empty nor full does not change the flag.
- R11: `irq_o` equals the request flag ANDed with `irq_en`.
- R12: When a write is accepted and a load happens in the same cycle, the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Software write strobe for a new word |
| wr_data | input | WIDTH | Word to enqueue |
| flag_wr | input | 1 | Software write strobe for the request flag |
| flag_wdata | input | 1 | Value written to the flag (only 0 acts) |
| fifo_en | input | 1 | FIFO operation enable |
| hold_empty | input | 1 | Shift engine holding register is empty |
| irq_en | input | 1 | Interrupt enable for the request flag |
| head_data | output | WIDTH | Oldest stored word |
| load_o | output | 1 | Handover strobe to the shift engine |
| count_o | output | $clog2(DEPTH+1) | Number of valid entries |
| req_o | output | 1 | Data-request flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Directed sequences step a depth-4 FIFO from empty to full and past it, and check that an over-full write is dropped. They also check that neither the first write nor a write of 1 to the flag moves it, and that disabling the FIFO freezes it. A long run then sweeps every combination of the six control inputs, in phases biased toward filling, draining and balance. Each cycle the bench compares the load strobe, head word, count, flag and interrupt against a queue model. The filling phases test the full-clear path against the empty-set path. The balanced phase exposes errors in simultaneous push and pop.

// File: rtl/txf_pkg.sv
package txf_pkg;
    typedef enum logic [1:0] {
        FLG_KEEP = 2'd0,
        FLG_SET  = 2'd1,
        FLG_CLR  = 2'd2
    } flag_act_e;
endpackage

// File: rtl/txf_ctrl.sv
module txf_ctrl #(
    parameter int DEPTH = 4,
    parameter int AW    = 2,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          fifo_en,
    input  logic          hold_empty,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count_q,
    output logic [CW-1:0] count_next
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ctrl_t;

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    ctrl_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        pop_ok  = fifo_en && hold_empty && (st_q.cnt != '0);
        push_ok = wr_en && (st_q.cnt != FULL);
        if (push_ok) begin
            st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
        end
        if (pop_ok) begin
            st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
        end
        if (push_ok && !pop_ok) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop_ok && !push_ok) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr     = st_q.wr;
    assign rd_ptr     = st_q.rd;
    assign count_q    = st_q.cnt;
    assign count_next = st_d.cnt;
endmodule

// File: rtl/txf_store.sv
module txf_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    parameter int AW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [DEPTH-1:0] sel;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_sel
        assign sel[gi] = we && (waddr == AW'(gi));
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = sel[i] ? wdata : mem_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/txf_reqflag.sv
module txf_reqflag #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count_next,
    input  logic          sw_wr,
    input  logic          sw_val,
    input  logic          irq_en,
    output logic          req_q,
    output logic          irq
);
    import txf_pkg::*;

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    flag_act_e act;
    logic      req_d;

    always_comb begin
        if (count_next == FULL) begin
            act = FLG_CLR;
        end else if (count_next == '0) begin
            act = FLG_SET;
        end else if (sw_wr && !sw_val) begin
            act = FLG_CLR;
        end else begin
            act = FLG_KEEP;
        end
        case (act)
            FLG_SET: req_d = 1'b1;
            FLG_CLR: req_d = 1'b0;
            default: req_d = req_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b1;
        end else begin
            req_q <= req_d;
        end
    end

    assign irq = req_q && irq_en;
endmodule

// File: rtl/tx_fifo_dreq.sv
module tx_fifo_dreq #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    input  logic             fifo_en,
    input  logic             hold_empty,
    input  logic             irq_en,
    output logic [WIDTH-1:0] head_data,
    output logic             load_o,
    output logic [CW-1:0]    count_o,
    output logic             req_o,
    output logic             irq_o
);
    logic          push_ok;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count_next;

    txf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .fifo_en    (fifo_en),
        .hold_empty (hold_empty),
        .push_ok    (push_ok),
        .pop_ok     (load_o),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .count_q    (count_o),
        .count_next (count_next)
    );

    txf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (push_ok),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_ptr),
        .rdata (head_data)
    );

    txf_reqflag #(.DEPTH(DEPTH), .CW(CW)) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_next (count_next),
        .sw_wr      (flag_wr),
        .sw_val     (flag_wdata),
        .irq_en     (irq_en),
        .req_q      (req_o),
        .irq        (irq_o)
    );
endmodule

// File: rtl/txf_chk.sv
module txf_chk #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          flag_wr,
    input logic          flag_wdata,
    input logic          fifo_en,
    input logic          hold_empty,
    input logic          irq_en,
    input logic          load_o,
    input logic [CW-1:0] count_o,
    input logic          req_o,
    input logic          irq_o
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= FULL);                                                   // R3
    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == FULL && !load_o) |=> count_o == FULL);                  // R3
    AST_NO_LOAD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> !load_o);                                              // R5
    AST_NO_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0) |-> !load_o);                                       // R4
    AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0) |-> req_o);                                         // R6
    AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == FULL) |-> !req_o);                                      // R9
    AST_WRITE_ONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && flag_wr && flag_wdata && !load_o) |=> !req_o);           // R8
    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && load_o && count_o != FULL) |=> $stable(count_o));         // R12
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_o);                                                // R11
endmodule

bind tx_fifo_dreq txf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .fifo_en    (fifo_en),
    .hold_empty (hold_empty),
    .irq_en     (irq_en),
    .load_o     (load_o),
    .count_o    (count_o),
    .req_o      (req_o),
    .irq_o      (irq_o)
);

// File: tb/sim_tx_fifo_dreq.sv
module sim_tx_fifo_dreq;
    localparam int WIDTH = 8;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             flag_wr = 1'b0;
    logic             flag_wdata = 1'b0;
    logic             fifo_en = 1'b0;
    logic             hold_empty = 1'b0;
    logic             irq_en = 1'b0;
    logic [WIDTH-1:0] head_data;
    logic             load_o;
    logic [CW-1:0]    count_o;
    logic             req_o;
    logic             irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    logic [WIDTH-1:0] mq[$];
    logic             mflag = 1'b1;

    always #4 clk = ~clk;

    tx_fifo_dreq #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .fifo_en(fifo_en),
        .hold_empty(hold_empty), .irq_en(irq_en), .head_data(head_data),
        .load_o(load_o), .count_o(count_o), .req_o(req_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic step(input logic w, input logic [WIDTH-1:0] d, input logic fw,
                        input logic fv, input logic en, input logic he,
                        input logic ie, input string tag);
        logic pop_e;
        logic push_e;
        int   n;
        @(negedge clk);
        wr_en = w; wr_data = d; flag_wr = fw; flag_wdata = fv;
        fifo_en = en; hold_empty = he; irq_en = ie;
        #1;
        pop_e = en && he && (mq.size() > 0);
        chk({tag, " R4 R5 load"}, int'(load_o), int'(pop_e));
        if (pop_e) chk({tag, " R2 head order"}, int'(head_data), int'(mq[0]));
        push_e = w && (mq.size() != DEPTH);
        if (pop_e) void'(mq.pop_front());
        if (push_e) mq.push_back(d);
        n = mq.size();
        if (n == DEPTH) mflag = 1'b0;
        else if (n == 0) mflag = 1'b1;
        else if (fw && !fv) mflag = 1'b0;
        @(posedge clk);
        #1;
        chk({tag, " R3 R12 count"}, int'(count_o), n);
        chk({tag, " R6 R7 R8 R9 R10 flag"}, int'(req_o), int'(mflag));
        chk({tag, " R11 irq"}, int'(irq_o), int'(mflag && ie));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lf;
        logic        w, he;
        irq_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset count", int'(count_o), 0);
        chk("R1 reset flag", int'(req_o), 1);
        chk("R11 reset irq", int'(irq_o), 1);
        rst_n = 1'b1;

        // R10: first write leaves flag set; R9: fourth write clears it
        step(1, 8'h11, 0, 0, 0, 0, 1, "R10 first push");
        step(1, 8'h22, 0, 0, 0, 0, 1, "R10 second push");
        step(1, 8'h33, 0, 0, 0, 0, 1, "R10 third push");
        step(1, 8'h44, 0, 0, 0, 0, 1, "R9 fill");
        // R3: write while full dropped
        step(1, 8'h55, 0, 0, 0, 0, 1, "R3 full write");
        // R5: disabled, engine ready, nothing moves
        step(0, 8'h00, 0, 0, 0, 1, 1, "R5 disabled");
        step(0, 8'h00, 0, 0, 0, 1, 1, "R5 disabled again");
        // R5: re-enable resumes with 0x11
        step(0, 8'h00, 0, 0, 1, 1, 1, "R5 resume");
        // R8: write 1 leaves the cleared flag at 0
        step(0, 8'h00, 1, 1, 0, 0, 1, "R8 write one");
        // R6: drain
        step(0, 8'h00, 0, 0, 1, 1, 1, "R6 drain");
        step(0, 8'h00, 0, 0, 1, 1, 1, "R6 drain");
        step(0, 8'h00, 0, 0, 1, 1, 0, "R6 empty");
        // R7: refill two, then software clear
        step(1, 8'h66, 0, 0, 0, 0, 1, "R10 refill");
        step(1, 8'h77, 0, 0, 0, 0, 1, "R10 refill");
        step(0, 8'h00, 1, 0, 0, 0, 1, "R7 clear");
        // R12: push and pop together
        step(1, 8'h88, 0, 0, 1, 1, 1, "R12 push pop");

        lf = 16'hACE1;
        for (int ph = 0; ph < 3; ph++) begin
            for (int k = 0; k < 2000; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                case (ph)
                    0: begin w = lf[0] | lf[1]; he = lf[2] & lf[3]; end
                    1: begin w = lf[0] & lf[1]; he = lf[2] | lf[3]; end
                    default: begin w = lf[0]; he = lf[2]; end
                endcase
                step(w, lf[15:8], lf[6] & lf[7], lf[8], lf[4] | lf[5], he,
                     lf[9], "sweep R2 R4");
            end
        end

        summary();
        $finish;
    end
endmodule